// File: doc/BRIEF.md
# Driver Fault Guard

This block provides the digital protection logic for a bank of eight low-side output drivers. Comparator bits from outside the block report per-channel overcurrent, die overtemperature and low supply. A single enable/reset pin is also an input. The block brings all of these into its clock domain. It filters each overcurrent bit by duration and latches a qualified fault so that only the affected channel is switched off. It produces a channel shutdown mask, a global disable and an active-low fault flag.

A thermal trip switches off every channel and pulls the flag low for as long as the comparator reports it. It needs no reset. An overcurrent trip stays latched until the enable/reset pin is driven high. Low supply is treated exactly like a high enable/reset level: it disables all outputs and clears latched trips. Low supply on its own never pulls the flag low. The analog thresholds and their hysteresis are outside the block.

Top module: `drv_fault_guard`

## Requirements
- R1: Every input passes through two flip-flop stages. A level applied before rising edge k reaches the outputs after rising edge k+1.
- R2: A channel trips only after its synchronised overcurrent bit has been high for FILT_CYC consecutive clock cycles. A run of FILT_CYC-1 cycles causes no trip, and any low cycle restarts the count from zero.
- R3: A trip sets only its own bit of `chanOffMask`. Bit i belongs to `ocIn[i]`, and a 1 means the channel is forced off.
- R4: A tripped channel stays off until the synchronised enable/reset is high or `rstN` is asserted. This holds even after its overcurrent bit drops.
- R5: While the synchronised enable/reset is high, `globalOff` is 1, all trips are cleared, and the flag is released unless overtemperature is active.
- R6: While the synchronised enable/reset or undervoltage is high, no new trip is latched and the duration counters stay at zero.
- R7: While synchronised overtemperature is high, `globalOff` is 1 and `faultFlagN` is 0. Both release as soon as it drops, with no reset pulse, and no trip is recorded.
- R8: Synchronised undervoltage forces `globalOff` to 1 and clears trips like enable/reset. On its own it leaves `faultFlagN` at 1.
- R9: `faultFlagN` is 0 exactly when some trip is latched or synchronised overtemperature is high.
- R10: After reset `chanOffMask` is 0, `globalOff` is 0 and `faultFlagN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ocIn | input | NCH | Per-channel overcurrent comparator bits (asynchronous) |
| overTempIn | input | 1 | Overtemperature comparator bit (asynchronous) |
| underVoltIn | input | 1 | Undervoltage comparator bit (asynchronous) |
| enRstIn | input | 1 | Enable/reset pin. High disables outputs and clears trips (asynchronous) |
| chanOffMask | output | NCH | Per-channel latched overcurrent shutdown |
| globalOff | output | 1 | Disable for all channels |
| faultFlagN | output | 1 | Active-low fault flag |

## Verification
The assertions assume that the comparator bits and the pin reach the block only through the two-stage synchroniser. They also assume that reset is applied before the first comparison, so the trip and counter relations start from a clean state. The stimulus changes inputs only on the falling clock edge. It keeps overcurrent bits stable for long runs, so that both qualified and sub-threshold pulses occur. Enable/reset, thermal and supply events are kept rare enough that trips can accumulate between clears.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // wipe every latched trip and counter
    logic latchEn;   // qualification of new overcurrent events allowed
  } faultStrobe_t;
endpackage

// File: rtl/drv_fault_sync.sv
module drv_fault_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageA;
  logic [WIDTH-1:0] stageB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA <= '0;
      stageB <= '0;
    end else begin
      stageA <= asyncIn;
      stageB <= stageA;
    end
  end

  assign syncOut = stageB;

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (stageB == $past(stageA))); // R1
endmodule

// File: rtl/drv_fault_chan.sv
module drv_fault_chan #(
  parameter int FILT_CYC = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic ocSync,
  input  logic clearAll,
  input  logic latchEn,
  output logic tripQ
);
  localparam int CNT_W = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FILT_CYC - 1);

  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      tripQ  <= 1'b0;
    end else if (clearAll) begin
      runCnt <= '0;
      tripQ  <= 1'b0;
    end else if (tripQ) begin
      runCnt <= '0;
    end else if (ocSync && latchEn) begin
      if (runCnt == LIMIT) begin
        runCnt <= '0;
        tripQ  <= 1'b1;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end else begin
      runCnt <= '0;
    end
  end

  AST_TRIP_NEEDS_OC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tripQ) |-> ($past(ocSync) && $past(latchEn))); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= LIMIT); // R2
  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (tripQ && !clearAll) |=> tripQ); // R4
  AST_CLEAR_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (!tripQ && runCnt == '0)); // R6
endmodule

// File: rtl/drv_fault_datapath.sv
module drv_fault_datapath
  import drv_fault_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int FILT_CYC = 100
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] ocIn,
  input  logic           overTempIn,
  input  logic           underVoltIn,
  input  logic           enRstIn,
  input  faultStrobe_t   strobe,
  output logic [NCH-1:0] tripVec,
  output logic           otSync,
  output logic           uvSync,
  output logic           enSync,
  output logic           anyTrip
);
  localparam int SYNC_W = NCH + 3;

  logic [SYNC_W-1:0] rawBus;
  logic [SYNC_W-1:0] syncBus;
  logic [NCH-1:0]    ocSync;

  assign rawBus = {enRstIn, underVoltIn, overTempIn, ocIn};

  drv_fault_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rawBus),
    .syncOut(syncBus)
  );

  assign ocSync = syncBus[NCH-1:0];
  assign otSync = syncBus[NCH];
  assign uvSync = syncBus[NCH+1];
  assign enSync = syncBus[NCH+2];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    drv_fault_chan #(.FILT_CYC(FILT_CYC)) u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .ocSync  (ocSync[ch]),
      .clearAll(strobe.clearAll),
      .latchEn (strobe.latchEn),
      .tripQ   (tripVec[ch])
    );
  end

  assign anyTrip = |tripVec;

  AST_CLEAR_MASK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (tripVec == '0)); // R5
  AST_NO_NEW_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchEn |=> ((tripVec & ~$past(tripVec)) == '0)); // R6
  AST_OT_NO_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    (otSync && ocSync == '0) |=> ((tripVec & ~$past(tripVec)) == '0)); // R7
endmodule

// File: rtl/drv_fault_ctrl.sv
module drv_fault_ctrl
  import drv_fault_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         otSync,
  input  logic         uvSync,
  input  logic         enSync,
  input  logic         anyTrip,
  output faultStrobe_t strobe,
  output logic         globalOff,
  output logic         faultFlagN
);
  logic disableReq;

  // Low supply behaves like a held-high enable/reset pin
  assign disableReq      = enSync | uvSync;
  assign strobe.clearAll = disableReq;
  assign strobe.latchEn  = ~disableReq;
  assign globalOff       = disableReq | otSync;
  assign faultFlagN      = ~(anyTrip | otSync);

  AST_UV_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (uvSync && !otSync && $past(uvSync)) |-> faultFlagN); // R8
  AST_EN_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (enSync && $past(enSync) && !otSync) |-> faultFlagN); // R5
  AST_OT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    otSync |-> (!faultFlagN && globalOff)); // R7
  AST_FLAG_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (!faultFlagN && !otSync) |-> anyTrip); // R9
endmodule

// File: rtl/drv_fault_guard.sv
module drv_fault_guard
  import drv_fault_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int FILT_CYC = 100
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] ocIn,
  input  logic           overTempIn,
  input  logic           underVoltIn,
  input  logic           enRstIn,
  output logic [NCH-1:0] chanOffMask,
  output logic           globalOff,
  output logic           faultFlagN
);
  faultStrobe_t strobe;
  logic otSync;
  logic uvSync;
  logic enSync;
  logic anyTrip;

  drv_fault_datapath #(.NCH(NCH), .FILT_CYC(FILT_CYC)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ocIn       (ocIn),
    .overTempIn (overTempIn),
    .underVoltIn(underVoltIn),
    .enRstIn    (enRstIn),
    .strobe     (strobe),
    .tripVec    (chanOffMask),
    .otSync     (otSync),
    .uvSync     (uvSync),
    .enSync     (enSync),
    .anyTrip    (anyTrip)
  );

  drv_fault_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .otSync    (otSync),
    .uvSync    (uvSync),
    .enSync    (enSync),
    .anyTrip   (anyTrip),
    .strobe    (strobe),
    .globalOff (globalOff),
    .faultFlagN(faultFlagN)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (chanOffMask == '0 || !rstN)); // R10
endmodule

// File: tb/drv_fault_guard_tb.sv
module drv_fault_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 8;
  localparam int FILT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] ocIn = '0;
  logic overTempIn = 1'b0;
  logic underVoltIn = 1'b0;
  logic enRstIn = 1'b0;
  logic [NCH-1:0] chanOffMask;
  logic globalOff;
  logic faultFlagN;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // independent reference state
  logic [NCH-1:0] mOcA, mOcB, mTrip;
  logic mOtA, mOtB, mUvA, mUvB, mEnA, mEnB;
  int mCnt [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  drv_fault_guard #(.NCH(NCH), .FILT_CYC(FILT)) u_dut (
    .clk(clk), .rstN(rstN), .ocIn(ocIn), .overTempIn(overTempIn),
    .underVoltIn(underVoltIn), .enRstIn(enRstIn),
    .chanOffMask(chanOffMask), .globalOff(globalOff), .faultFlagN(faultFlagN)
  );

  task automatic modelClear();
    mOcA = '0; mOcB = '0; mTrip = '0;
    mOtA = 0; mOtB = 0; mUvA = 0; mUvB = 0; mEnA = 0; mEnB = 0;
    for (int i = 0; i < NCH; i++) mCnt[i] = 0;
  endtask

  task automatic modelEdge();
    logic dis;
    dis = mEnB | mUvB;
    for (int i = 0; i < NCH; i++) begin
      if (dis) begin mCnt[i] = 0; mTrip[i] = 1'b0; end
      else if (mTrip[i]) mCnt[i] = 0;
      else if (mOcB[i]) begin
        if (mCnt[i] == FILT-1) begin mTrip[i] = 1'b1; mCnt[i] = 0; end
        else mCnt[i]++;
      end else mCnt[i] = 0;
    end
    mOcB = mOcA; mOcA = ocIn;
    mOtB = mOtA; mOtA = overTempIn;
    mUvB = mUvA; mUvA = underVoltIn;
    mEnB = mEnA; mEnA = enRstIn;
  endtask

  task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    check1({tag, " R3 mask"}, 32'(chanOffMask), 32'(mTrip));
    check1({tag, " R5 globalOff"}, 32'(globalOff), 32'(mEnB | mUvB | mOtB));
    check1({tag, " R9 flag"}, 32'(faultFlagN), 32'(!((|mTrip) || mOtB)));
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic cycles(input int n, input string tag);
    for (int k = 0; k < n; k++) cycle(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h5A17);
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check1("R10 mask", 32'(chanOffMask), 0);
    check1("R10 globalOff", 32'(globalOff), 0);
    check1("R10 flag", 32'(faultFlagN), 1);
    rstN = 1'b1;
    cycles(2, "idle");

    // R1: enable rises, visible after second edge only
    enRstIn = 1'b1;
    cycle("R1a");
    check1("R1 not yet", 32'(globalOff), 0);
    cycle("R1b");
    check1("R1 visible", 32'(globalOff), 1);
    enRstIn = 1'b0;
    cycles(4, "R1 settle");

    // R2: FILT-1 run does not trip
    ocIn[0] = 1'b1;
    cycles(FILT-1, "R2 short");
    ocIn[0] = 1'b0;
    cycles(5, "R2 short");
    check1("R2 short pulse", 32'(chanOffMask), 0);

    // R2: drop restarts count
    ocIn[0] = 1'b1; cycles(FILT-2, "R2 restart");
    ocIn[0] = 1'b0; cycle("R2 restart");
    ocIn[0] = 1'b1; cycles(FILT-2, "R2 restart");
    ocIn[0] = 1'b0; cycles(5, "R2 restart");
    check1("R2 restart", 32'(chanOffMask), 0);

    // R2/R3: full run trips only channel 2
    ocIn[2] = 1'b1;
    cycles(FILT, "R3 trip");
    ocIn[2] = 1'b0;
    cycles(4, "R3 trip");
    check1("R3 own bit", 32'(chanOffMask), 32'h04);
    check1("R9 flag low", 32'(faultFlagN), 0);

    // R4: holds after oc drops
    cycles(30, "R4 hold");
    check1("R4 hold", 32'(chanOffMask), 32'h04);

    // R6: held oc during enable/reset never trips
    enRstIn = 1'b1; ocIn[5] = 1'b1;
    cycles(3 * FILT, "R6 suppress");
    check1("R5 cleared", 32'(chanOffMask), 0);
    check1("R5 flag released", 32'(faultFlagN), 1);
    check1("R6 suppress", 32'(chanOffMask), 0);
    ocIn[5] = 1'b0; enRstIn = 1'b0;
    cycles(4, "R6 settle");
    check1("R6 after", 32'(chanOffMask), 0);

    // R7: thermal, self-clearing, no trip
    overTempIn = 1'b1;
    cycles(20, "R7 hot");
    check1("R7 flag", 32'(faultFlagN), 0);
    check1("R7 off", 32'(globalOff), 1);
    overTempIn = 1'b0;
    cycles(3, "R7 cool");
    check1("R7 release flag", 32'(faultFlagN), 1);
    check1("R7 release off", 32'(globalOff), 0);
    check1("R7 no trip", 32'(chanOffMask), 0);

    // R8: UV clears trip, flag stays high
    ocIn[7] = 1'b1; cycles(FILT + 2, "R8 prep"); ocIn[7] = 1'b0;
    cycles(3, "R8 prep");
    check1("R8 prep trip", 32'(chanOffMask), 32'h80);
    underVoltIn = 1'b1;
    cycles(6, "R8 uv");
    check1("R8 off", 32'(globalOff), 1);
    check1("R8 flag high", 32'(faultFlagN), 1);
    check1("R8 cleared", 32'(chanOffMask), 0);
    underVoltIn = 1'b0;
    cycles(4, "R8 done");

    // random phase against the reference model
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NCH; i++)
        if ($urandom % 40 == 0) ocIn[i] = ~ocIn[i];
      enRstIn = ($urandom % 180 == 0);
      if ($urandom % 150 == 0) overTempIn = ~overTempIn;
      if ($urandom % 260 == 0) underVoltIn = ~underVoltIn;
      cycle("R2 R4 R7 R8 rand");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule